// File: doc/BRIEF.md
# Two-Wire Serial Slave Controller

This block is the slave side of a two-wire serial bus (clock line plus open-drain data line) for a byte-wide storage array. A system clock oversamples both bus lines. The block finds start and stop conditions and shifts in the slave address byte. It compares that byte with a strapped pin address and acknowledges on the ninth bus clock. It then runs either a write sequence or a read sequence. The write sequence takes a word address and then data bytes. The read sequence returns bytes from the current pointer. The array itself is outside the block and is reached through plain ports. A write strobe carries the address and data. A read address is returned by combinational read data. A one-cycle pulse starts the programming cycle, and a busy level reports that the cycle is still running.

A host can poll for the end of a programming cycle. While the busy input is high, the block refuses every address byte, so the host repeats start plus address until it sees an acknowledge. A start condition at any point abandons the current transfer and waits for a new address. Two device-type codes are accepted. One selects the normal array and the other selects a protection space, and an output level reports which of the two the current transfer uses. `ADDR_W` must not exceed 8, and `SYNC_STAGES` must be at least 2.

Top module: `twoWireSlave`

## Requirements
- R1: A start condition (data falling while clock is high) at any point, including in the middle of a data byte, abandons the transfer without a write strobe, and the next eight clock rises are taken as a slave address byte. A stop condition (data rising while clock is high) returns the block to idle.
- R2: An address byte is accepted only when bits 7:4 equal 1010 (array) or 0110 (protection space), bits 3:1 equal `devPins[2:0]`, and bit 0 gives the direction (1 = read). On any other byte the block leaves the data line released and ignores all further bytes until the next start or stop condition.
- R3: For each accepted address byte, and for each word-address or data byte received after an accepted write address, the block holds the data line low for the whole high period of the ninth clock. It never changes its drive while the clock is high.
- R4: While `progBusy` is high, every address byte is refused (no acknowledge), so that a host can poll.
- R5: In a write, the first byte after the address loads the pointer. Every following byte produces a one-cycle `wrReq` with `wrAddr` = pointer and `wrData` = the byte. After each of these bytes the low `PAGE_BITS` bits of the pointer increment and wrap, and the upper bits stay unchanged.
- R6: `progStart` pulses for one cycle after a stop condition only when at least one `wrReq` has occurred since the previous stop. Read-only and refused transfers never pulse it.
- R7: In a read, bytes are taken from `rdData` at `rdAddr` and sent MSB first, one bit per clock. After each byte the full pointer increments and wraps from all ones to zero. The pointer survives a repeated start, so a write of just the word address followed by a repeated start and a read address reads from that word address.
- R8: When the host answers a read byte with no acknowledge (data high on the ninth clock), the block stops driving and leaves the data line released until the next start or stop condition.
- R9: `spaceSel` is 1 after an accepted address with code 0110 and 0 after an accepted address with code 1010.
- R10: During and after reset the data line is released, and `wrReq` and `progStart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| devPins | input | 3 | Strapped slave address bits |
| sdaOe | output | 1 | 1 pulls the data line low (open-drain enable) |
| spaceSel | output | 1 | 1 when the current transfer targets the protection space |
| wrReq | output | 1 | One-cycle array write strobe |
| wrAddr | output | ADDR_W | Array write address |
| wrData | output | 8 | Array write data |
| rdAddr | output | ADDR_W | Array read address |
| rdData | input | 8 | Array read data for `rdAddr` |
| progBusy | input | 1 | High while a programming cycle runs |
| progStart | output | 1 | One-cycle request to begin programming |

## Verification
The assertions assume that the bus lines move slowly compared with the system clock. Every data-line change must sit several clocks away from any clock-line edge, so that the synchronised copies never see both lines move in the same cycle. They also assume that `progBusy` stays steady across an address decision. The stimulus uses a bus quarter-period of eight system clocks. It changes the data line only in the middle of a clock-low phase, except for start and stop, which change it in the middle of a clock-high phase. The busy model rises only after a `progStart` pulse and stays high for a fixed count. Random addresses and data are mixed with directed cases: page wrap, pointer wrap, repeated start, an abandoned byte, polling, and refused addresses.

// File: rtl/twsPkg.sv
package twsPkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef logic [CNT_W-1:0] bitCnt_t;

  localparam bitCnt_t CNT_FULL = bitCnt_t'(BYTE_W);
  localparam bitCnt_t CNT_LAST = bitCnt_t'(BYTE_W - 1);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WORD,
    S_WORD_ACK,
    S_WDATA,
    S_DATA_ACK,
    S_TX,
    S_MACK,
    S_MACK_OK,
    S_WAIT
  } twsState_e;

  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadRd;
    logic loadPtr;
    logic incWr;
    logic incRd;
  } twsStrobe_t;

endpackage

// File: rtl/twsLineSync.sv
module twsLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  // idle bus is high, so reset to ones to avoid phantom events
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsStrobe_t        stb,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] shiftReg,
  output bitCnt_t           bitCnt,
  output logic [ADDR_W-1:0] ptr
);

  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptrWrNext;
  logic [ADDR_W-1:0] ptrRdNext;

  assign ptrRdNext = ptr + PTR_ONE;

  generate
    if (PAGE_BITS >= ADDR_W) begin : gFullWrap
      assign ptrWrNext = ptr + PTR_ONE;
    end else begin : gPageWrap
      localparam logic [PAGE_BITS-1:0] PG_ONE = PAGE_BITS'(1);
      logic [PAGE_BITS-1:0] pageLow;
      assign pageLow   = ptr[PAGE_BITS-1:0] + PG_ONE;
      assign ptrWrNext = {ptr[ADDR_W-1:PAGE_BITS], pageLow};

      // R5
      page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        stb.incWr |=> ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (stb.loadRd)        shiftReg <= rdData;
      else if (stb.shiftIn)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      else if (stb.shiftOut) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};

      if (stb.clrCnt)                     bitCnt <= '0;
      else if (stb.shiftIn | stb.shiftOut) bitCnt <= bitCnt + bitCnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.loadPtr) begin
      ptr <= shiftReg[ADDR_W-1:0];
    end else if (stb.incWr) begin
      ptr <= ptrWrNext;
    end else if (stb.incRd) begin
      ptr <= ptrRdNext;
    end
  end

  // R7
  ptr_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadPtr, stb.incWr, stb.incRd}));

  // R3
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_FULL);

endmodule

// File: rtl/twsCtrl.sv
module twsCtrl
  import twsPkg::*;
#(
  parameter logic [3:0] MEM_CODE  = 4'b1010,
  parameter logic [3:0] PROT_CODE = 4'b0110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLvl,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] shiftReg,
  input  bitCnt_t           bitCnt,
  input  logic [2:0]        devPins,
  input  logic              progBusy,
  output twsStrobe_t        stb,
  output logic              sdaOe,
  output logic              wrReq,
  output logic              progStart,
  output logic              spaceSel
);

  twsState_e state;
  twsState_e nxtState;
  logic isRead;
  logic wrPending;
  logic byteFull;
  logic typeOk;
  logic addrOk;
  logic addrTake;

  assign byteFull = (bitCnt == CNT_FULL);
  assign typeOk   = (shiftReg[7:4] == MEM_CODE) || (shiftReg[7:4] == PROT_CODE);
  assign addrOk   = typeOk && (shiftReg[3:1] == devPins) && !progBusy;

  always_comb begin
    stb      = '0;
    nxtState = state;
    addrTake = 1'b0;
    unique case (state)
      S_ADDR: begin
        if (sclRise && !byteFull) stb.shiftIn = 1'b1;
        if (sclFall && byteFull) begin
          stb.clrCnt = 1'b1;
          addrTake   = addrOk;
          nxtState   = addrOk ? S_ADDR_ACK : S_WAIT;
        end
      end
      S_ADDR_ACK: begin
        if (sclFall) begin
          if (isRead) begin
            stb.loadRd = 1'b1;
            stb.incRd  = 1'b1;
            stb.clrCnt = 1'b1;
            nxtState   = S_TX;
          end else begin
            nxtState = S_WORD;
          end
        end
      end
      S_WORD: begin
        if (sclRise && !byteFull) stb.shiftIn = 1'b1;
        if (sclFall && byteFull) begin
          stb.loadPtr = 1'b1;
          stb.clrCnt  = 1'b1;
          nxtState    = S_WORD_ACK;
        end
      end
      S_WORD_ACK, S_DATA_ACK: begin
        if (sclFall) nxtState = S_WDATA;
      end
      S_WDATA: begin
        if (sclRise && !byteFull) stb.shiftIn = 1'b1;
        if (sclFall && byteFull) begin
          stb.incWr  = 1'b1;
          stb.clrCnt = 1'b1;
          nxtState   = S_DATA_ACK;
        end
      end
      S_TX: begin
        if (sclFall) begin
          if (bitCnt == CNT_LAST) begin
            stb.clrCnt = 1'b1;
            nxtState   = S_MACK;
          end else begin
            stb.shiftOut = 1'b1;
          end
        end
      end
      S_MACK: begin
        if (sclRise) nxtState = sdaLvl ? S_WAIT : S_MACK_OK;
      end
      S_MACK_OK: begin
        if (sclFall) begin
          stb.loadRd = 1'b1;
          stb.incRd  = 1'b1;
          stb.clrCnt = 1'b1;
          nxtState   = S_TX;
        end
      end
      default: ;
    endcase

    if (startDet) begin
      stb        = '0;
      stb.clrCnt = 1'b1;
      addrTake   = 1'b0;
      nxtState   = S_ADDR;
    end else if (stopDet) begin
      stb      = '0;
      addrTake = 1'b0;
      nxtState = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      isRead    <= 1'b0;
      spaceSel  <= 1'b0;
      wrPending <= 1'b0;
      progStart <= 1'b0;
    end else begin
      state     <= nxtState;
      progStart <= stopDet & wrPending;
      if (stopDet)        wrPending <= 1'b0;
      else if (stb.incWr) wrPending <= 1'b1;
      if (addrTake) begin
        isRead   <= shiftReg[0];
        spaceSel <= (shiftReg[7:4] == PROT_CODE);
      end
    end
  end

  assign wrReq = stb.incWr;

  always_comb begin
    unique case (state)
      S_ADDR_ACK, S_WORD_ACK, S_DATA_ACK: sdaOe = 1'b1;
      S_TX:                               sdaOe = ~shiftReg[BYTE_W-1];
      default:                            sdaOe = 1'b0;
    endcase
  end

  // R3
  sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && !startDet && !stopDet) |=> $stable(sdaOe));

  // R1
  start_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_ADDR) && !wrReq);

  // R8
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> !sdaOe);

  // R6
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  // R4
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADDR && sclFall && byteFull && progBusy && !startDet && !stopDet)
      |=> state == S_WAIT);

endmodule

// File: rtl/twoWireSlave.sv
module twoWireSlave
  import twsPkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_BITS   = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] MEM_CODE    = 4'b1010,
  parameter logic [3:0] PROT_CODE   = 4'b0110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devPins,
  output logic              sdaOe,
  output logic              spaceSel,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [BYTE_W-1:0] rdData,
  input  logic              progBusy,
  output logic              progStart
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  twsStrobe_t stb;
  logic [BYTE_W-1:0] shiftReg;
  bitCnt_t bitCnt;
  logic [ADDR_W-1:0] ptr;

  twsLineSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  twsCtrl #(.MEM_CODE(MEM_CODE), .PROT_CODE(PROT_CODE)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .shiftReg(shiftReg), .bitCnt(bitCnt), .devPins(devPins), .progBusy(progBusy),
    .stb(stb), .sdaOe(sdaOe), .wrReq(wrReq), .progStart(progStart),
    .spaceSel(spaceSel)
  );

  twsDatapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaLvl), .rdData(rdData),
    .shiftReg(shiftReg), .bitCnt(bitCnt), .ptr(ptr)
  );

  assign wrAddr = ptr;
  assign wrData = shiftReg;
  assign rdAddr = ptr;

endmodule

// File: tb/test_twoWireSlave.sv
module test_twoWireSlave;

  localparam int CLK_PERIOD  = 10;
  localparam int Q           = 8;
  localparam int BUSY_CYCLES = 400;
  localparam logic [2:0] PINS  = 3'b101;
  localparam logic [3:0] MEMC  = 4'b1010;
  localparam logic [3:0] PROTC = 4'b0110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaOe, spaceSel, wrReq, progStart, progBusy;
  logic [7:0] wrAddr, wrData, rdAddr, rdData;

  logic [7:0] mem [256];
  logic [7:0] refMem [256];
  int busyCnt;
  int wrCount;
  int progCount;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaBus   = sdaM & ~sdaOe;
  assign rdData   = mem[rdAddr];
  assign progBusy = (busyCnt != 0);

  twoWireSlave i_twoWireSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .devPins(PINS),
    .sdaOe(sdaOe), .spaceSel(spaceSel), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .progBusy(progBusy),
    .progStart(progStart)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      busyCnt <= 0;
      wrCount <= 0;
      progCount <= 0;
    end else begin
      if (wrReq) begin
        mem[wrAddr] <= wrData;
        wrCount <= wrCount + 1;
      end
      if (progStart) begin
        busyCnt <= BUSY_CYCLES;
        progCount <= progCount + 1;
      end else if (busyCnt != 0) begin
        busyCnt <= busyCnt - 1;
      end
    end
  end

  function automatic logic [7:0] pageNext(logic [7:0] a);
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] addrByte(logic [3:0] code, logic [2:0] pins, logic rd);
    return {code, pins, rd};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    sdaM = 1'b0; q();
    sclM = 1'b0; q();
  endtask

  task automatic busStop();
    sdaM = 1'b0; q();
    sclM = 1'b1; q();
    sdaM = 1'b1; q(2);
  endtask

  task automatic txBit(logic b);
    sdaM = b; q();
    sclM = 1'b1; q(2);
    sclM = 1'b0; q();
  endtask

  task automatic txByte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) txBit(b[i]);
    sdaM = 1'b1; q();
    sclM = 1'b1; q();
    ack = ~sdaBus;
    q();
    sclM = 1'b0; q();
  endtask

  task automatic rxByte(output logic [7:0] b, input logic mAck);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sdaM = 1'b1; q();
      sclM = 1'b1; q();
      b = {b[6:0], sdaBus};
      q();
      sclM = 1'b0; q();
    end
    txBit(~mAck);
  endtask

  task automatic waitIdle();
    q(2);
    while (progBusy) @(negedge clk);
    q(1);
  endtask

  // write n random bytes from address a, then check strobes and programming
  task automatic writeAt(logic [7:0] a, int n);
    logic ack;
    logic [7:0] pa;
    logic [7:0] d;
    int w0, p0;
    w0 = wrCount;
    p0 = progCount;
    pa = a;
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    chk("R3 write address ack", ack, 1);
    txByte(a, ack);
    chk("R3 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      txByte(d, ack);
      chk("R3 data ack", ack, 1);
      refMem[pa] = d;
      pa = pageNext(pa);
    end
    busStop();
    chk("R5 write strobe count", wrCount - w0, n);
    chk("R6 programming pulse", progCount - p0, 1);
    waitIdle();
  endtask

  // pointer set by word address, repeated start, then sequential read
  task automatic readAt(logic [7:0] a, int n);
    logic ack;
    logic [7:0] b;
    logic [7:0] ra;
    int p0;
    p0 = progCount;
    ra = a;
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    txByte(a, ack);
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b1), ack);
    chk("R3 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rxByte(b, i < n - 1);
      chk("R7 read data", b, refMem[ra]);
      ra = ra + 8'd1;
    end
    busStop();
    chk("R6 no programming after read", progCount - p0, 0);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int w0, p0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) refMem[i] = 8'(i * 7 + 3);

    repeat (3) @(negedge clk);
    chk("R10 data line released in reset", sdaOe, 0);
    rstN = 1'b1;
    q(2);
    chk("R10 data line released after reset", sdaOe, 0);
    chk("R10 no write strobe after reset", wrCount, 0);
    chk("R10 no programming after reset", progCount, 0);

    // R2: wrong pins, refused and later bytes ignored
    w0 = wrCount;
    busStart();
    txByte(addrByte(MEMC, PINS ^ 3'b001, 1'b0), ack);
    chk("R2 wrong pins nack", ack, 0);
    txByte(8'h10, ack);
    chk("R2 ignored byte nack", ack, 0);
    txByte(8'hAA, ack);
    busStop();
    chk("R2 no write when unselected", wrCount - w0, 0);
    chk("R6 no programming when unselected", progCount, 0);

    // R2: unknown device-type code
    busStart();
    txByte(addrByte(4'b1001, PINS, 1'b0), ack);
    chk("R2 wrong type code nack", ack, 0);
    busStop();

    // R5 byte write
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    chk("R3 address ack", ack, 1);
    chk("R9 array space selected", spaceSel, 0);
    txByte(8'h25, ack);
    txByte(8'hC3, ack);
    chk("R3 data ack", ack, 1);
    busStop();
    refMem[8'h25] = 8'hC3;
    q();
    chk("R5 byte written", mem[8'h25], 8'hC3);
    chk("R6 programming after write", progCount, 1);

    // R4 polling while busy
    p0 = progCount;
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    chk("R4 poll refused while busy", ack, 0);
    busStop();
    waitIdle();
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    chk("R4 poll accepted when idle", ack, 1);
    busStop();
    chk("R6 no programming after polls", progCount - p0, 0);

    // R7 random read and full-width pointer wrap
    readAt(8'h25, 1);
    readAt(8'hFE, 3);

    // R8 host no-ack ends the read
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    txByte(8'h10, ack);
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b1), ack);
    rxByte(b, 1'b0);
    chk("R7 single read", b, refMem[8'h10]);
    rxByte(b, 1'b0);
    chk("R8 line released after no-ack", b, 8'hFF);
    busStop();

    // R5 page wrap
    writeAt(8'h3D, 5);
    chk("R5 page wrap low", mem[8'h30], refMem[8'h30]);
    chk("R5 page wrap next", mem[8'h31], refMem[8'h31]);
    chk("R5 next page untouched", mem[8'h40], refMem[8'h40]);
    chk("R5 last in page", mem[8'h3F], refMem[8'h3F]);

    // R1 start aborts a partial data byte
    w0 = wrCount;
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    txByte(8'h50, ack);
    for (int i = 0; i < 4; i++) txBit(1'b0);
    busStart();
    txByte(addrByte(MEMC, PINS, 1'b0), ack);
    chk("R1 address after abort ack", ack, 1);
    txByte(8'h51, ack);
    txByte(8'h77, ack);
    busStop();
    refMem[8'h51] = 8'h77;
    q();
    chk("R1 one strobe after abort", wrCount - w0, 1);
    chk("R1 aborted byte not written", mem[8'h50], refMem[8'h50]);
    chk("R1 next write lands", mem[8'h51], 8'h77);
    waitIdle();

    // R9 protection space code
    busStart();
    txByte(addrByte(PROTC, PINS, 1'b0), ack);
    chk("R2 protection code ack", ack, 1);
    chk("R9 protection space selected", spaceSel, 1);
    busStop();

    // random writes and readback
    for (int it = 0; it < 12; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      n = 1 + int'($urandom % 3);
      if (it % 4 == 3) begin
        busStart();
        txByte(addrByte(MEMC, PINS ^ 3'b010, 1'b1), ack);
        chk("R2 random wrong pins nack", ack, 0);
        busStop();
      end
      writeAt(a, n);
      for (int k = 0; k < n; k++) begin
        readAt(a, 1);
        a = pageNext(a);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule